// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block is a two-wire bus master that runs once after reset. It pulls a block of configuration bytes out of a single dedicated serial EEPROM and hands each byte to a register bank. The two bus lines are driven through open-drain enables: a 1 on an enable pulls the line low, and a 0 lets the external pull-up hold it high. The master owns the bus. No other master, no clock stretching and no write traffic are expected.

The access pattern is fixed. The master sets the EEPROM's internal pointer to a start address with a write header, then reads back to back until the requested number of bytes has arrived. Each byte appears for one cycle on a strobe, together with its EEPROM address and its value. A done flag marks the end of the load, and an error flag marks a load that the EEPROM refused. While reset is held, the block leaves both lines floating so that an external programmer can reach the EEPROM.

Top module: `i2c_seq_loader`

## Requirements
- R1: While rst_ni is low, sda_oe_o and scl_oe_o are 0 (both lines released), and done_o, err_o and byte_vld_o are 0. This also holds when reset is asserted in the middle of a load.
- R2: A quarter bit Q is ceil(CLK_HZ / (4*SCL_HZ)) clock cycles. Every SCL high phase that SCL low ends, including the first address bit and the high phase of a START, lasts 2*Q+1 cycles.
- R3: The bus traffic is, in order: START, the byte 0xA0 (device address 1010000 with write bit 0), the word address equal to start_addr_i, a repeated START, the byte 0xA1 (read bit 1), the data bytes, and STOP. Bytes go MSB first.
- R4: SDA changes only while SCL is low, except at START and STOP. A full load therefore shows exactly two START conditions and one STOP.
- R5: After every data byte except the last, the master drives an acknowledge (SDA low in the ninth clock). After the last byte it leaves SDA high (NACK).
- R6: For data byte i, byte_vld_o is high for exactly one cycle, byte_addr_o = start_addr_i + i, and byte_data_o holds the byte read. Exactly byte_cnt_i strobes occur.
- R7: If the EEPROM does not acknowledge the write header, the word address or the read header, err_o is set, a STOP is issued, done_o follows, and no byte strobe occurs.
- R8: done_o rises after the STOP, whether or not the load succeeded, and stays high until reset. Both lines stay released from then on.
- R9: With byte_cnt_i = 0, the master sends STOP right after the word-address acknowledge. There is no repeated START, no strobe and no error.
- R10: byte_addr_o wraps modulo 256, so a load that starts at 0xFE continues at 0x00 after 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the load starts when it is released |
| sda_i | input | 1 | SDA line read-back |
| start_addr_i | input | 8 | First EEPROM word address; must be stable while the load runs |
| byte_cnt_i | input | CNT_W | Number of bytes to read; must be stable while the load runs |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| scl_oe_o | output | 1 | Pulls SCL low when 1 |
| done_o | output | 1 | Load finished; held until reset |
| err_o | output | 1 | EEPROM missed an acknowledge in an address phase |
| byte_vld_o | output | 1 | One-cycle strobe for each received byte |
| byte_addr_o | output | 8 | EEPROM address of the strobed byte |
| byte_data_o | output | 8 | Value of the strobed byte |

## Verification
Two things fall on the same clock edge: the strobe of a finished byte with its counter increment, and the decision whether the next ninth clock carries ACK or NACK, which reads that counter. The bench provokes this edge with loads of 1, 4 and 16 bytes and with a start address just below the wrap point. A behavioural EEPROM on the bench logs every acknowledge the master gives, and a monitor checks each strobe's address and data. A second pairing comes from making the EEPROM refuse each of the three address phases in turn: there the error path and the repeated-START path compete for the same acknowledge slot, and the run is judged on the flags, on the START and STOP counts and on the absence of strobes.

// File: rtl/i2c_seq_loader_pkg.sv
package i2c_seq_loader_pkg;
  localparam logic [6:0] DEV_ADDR = 7'b1010000;

  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WR, BC_RD} bus_cmd_e;

  typedef enum logic [2:0] {
    SQ_START, SQ_TX, SQ_ACKRX, SQ_RX, SQ_ACKTX, SQ_STOP, SQ_DONE
  } seq_st_e;

  function automatic int unsigned qtr_cycles(int unsigned clk_hz, int unsigned scl_hz);
    return (clk_hz + 4 * scl_hz - 1) / (4 * scl_hz);
  endfunction
endpackage

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
  parameter int unsigned QTR = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  if (QTR <= 1) begin : g_direct
    assign tick_o = en_i;
  end else begin : g_cnt
    localparam int unsigned CW = $clog2(QTR);
    logic [CW-1:0] cnt_q;
    assign tick_o = en_i && (cnt_q == CW'(QTR - 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!en_i || tick_o) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_seq_loader_pkg::*;
#(
  parameter int unsigned QTR = 125
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     go_i,
  input  bus_cmd_e cmd_i,
  input  logic     wbit_i,
  input  logic     sda_i,
  output logic     done_o,
  output logic     rbit_o,
  output logic     sda_oe_o,
  output logic     scl_oe_o
);
  logic     busy_q, tick, wbit_q, rbit_q, sda_oe_q, scl_oe_q;
  logic [1:0] q_q, q_nx;
  bus_cmd_e cmd_q, c_nx;
  logic     b_nx, load, scl_nx, sda_nx;

  i2c_qtr_tick #(.QTR(QTR)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_q),
    .tick_o (tick)
  );

  assign done_o   = busy_q && tick && (q_q == 2'd3);
  assign rbit_o   = rbit_q;
  assign sda_oe_o = sda_oe_q;
  assign scl_oe_o = scl_oe_q;

  // quarters: 0 SCL low, 1 set SDA, 2-3 SCL high (START/STOP edge at 3)
  always_comb begin
    load = 1'b0;
    q_nx = q_q + 2'd1;
    c_nx = cmd_q;
    b_nx = wbit_q;
    if (go_i && !busy_q) begin
      load = 1'b1;
      q_nx = 2'd0;
      c_nx = cmd_i;
      b_nx = wbit_i;
    end else if (tick && q_q != 2'd3) begin
      load = 1'b1;
    end
    scl_nx = scl_oe_q;
    sda_nx = sda_oe_q;
    unique case (q_nx)
      2'd0: scl_nx = 1'b1;
      2'd1: begin
        unique case (c_nx)
          BC_START: sda_nx = 1'b0;
          BC_STOP:  sda_nx = 1'b1;
          BC_WR:    sda_nx = !b_nx;
          default:  sda_nx = 1'b0;
        endcase
      end
      2'd2: scl_nx = 1'b0;
      default: begin
        if (c_nx == BC_START)     sda_nx = 1'b1;
        else if (c_nx == BC_STOP) sda_nx = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      q_q      <= 2'd0;
      cmd_q    <= BC_STOP;
      wbit_q   <= 1'b1;
      rbit_q   <= 1'b1;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
    end else begin
      if (load) begin
        q_q      <= q_nx;
        cmd_q    <= c_nx;
        wbit_q   <= b_nx;
        scl_oe_q <= scl_nx;
        sda_oe_q <= sda_nx;
      end
      if (go_i && !busy_q) busy_q <= 1'b1;
      else if (done_o)     busy_q <= 1'b0;
      if (busy_q && tick && q_q == 2'd2) rbit_q <= sda_i;
    end
  end

  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !scl_oe_q && !$past(scl_oe_q) && (cmd_q == BC_WR || cmd_q == BC_RD))
      |-> $stable(sda_oe_q)); // R4
  AST_GO_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q); // R3
endmodule

// File: rtl/i2c_seq_loader.sv
module i2c_seq_loader
  import i2c_seq_loader_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned SCL_HZ = 100_000,
  parameter int unsigned CNT_W  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic [7:0]       start_addr_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  output logic             sda_oe_o,
  output logic             scl_oe_o,
  output logic             done_o,
  output logic             err_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_addr_o,
  output logic [7:0]       byte_data_o
);
  localparam int unsigned QTR = qtr_cycles(CLK_HZ, SCL_HZ);

  seq_st_e          st_q;
  logic [1:0]       idx_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q, sa_q, addr_q, data_q;
  logic [CNT_W-1:0] nb_q, cnt_q;
  logic             go_q, done_q, err_q, vld_q;
  bus_cmd_e         cmd;
  logic             wbit, eng_done, rbit, eng_sda, eng_scl, last_byte;

  i2c_bit_engine #(.QTR(QTR)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go_q),
    .cmd_i    (cmd),
    .wbit_i   (wbit),
    .sda_i    (sda_i),
    .done_o   (eng_done),
    .rbit_o   (rbit),
    .sda_oe_o (eng_sda),
    .scl_oe_o (eng_scl)
  );

  // bus must float during reset even before the first edge
  assign sda_oe_o    = rst_ni & eng_sda;
  assign scl_oe_o    = rst_ni & eng_scl;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign byte_vld_o  = vld_q;
  assign byte_addr_o = addr_q;
  assign byte_data_o = data_q;
  assign last_byte   = (nb_q == cnt_q);

  always_comb begin
    cmd  = BC_RD;
    wbit = 1'b1;
    unique case (st_q)
      SQ_START:         cmd = BC_START;
      SQ_STOP, SQ_DONE: cmd = BC_STOP;
      SQ_TX:    begin cmd = BC_WR; wbit = sh_q[7];   end
      SQ_ACKTX: begin cmd = BC_WR; wbit = last_byte; end
      default:          cmd = BC_RD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_START;
      idx_q  <= 2'd0;
      bit_q  <= 3'd0;
      sh_q   <= '0;
      nb_q   <= '0;
      cnt_q  <= '0;
      sa_q   <= '0;
      go_q   <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= 1'b0;
      go_q  <= 1'b0;
      if (st_q == SQ_START && idx_q == 2'd0) begin
        sa_q  <= start_addr_i;
        cnt_q <= byte_cnt_i;
      end
      if (eng_done) begin
        go_q <= (st_q != SQ_STOP);
        unique case (st_q)
          SQ_START: begin
            st_q  <= SQ_TX;
            bit_q <= 3'd7;
            sh_q  <= {DEV_ADDR, idx_q == 2'd2};
          end
          SQ_TX: begin
            if (bit_q == 3'd0) st_q <= SQ_ACKRX;
            else begin
              bit_q <= bit_q - 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
          SQ_ACKRX: begin
            if (rbit) begin
              err_q <= 1'b1;
              st_q  <= SQ_STOP;
            end else if (idx_q == 2'd0) begin
              idx_q <= 2'd1;
              sh_q  <= sa_q;
              bit_q <= 3'd7;
              st_q  <= SQ_TX;
            end else if (idx_q == 2'd1) begin
              if (cnt_q == '0) st_q <= SQ_STOP;
              else begin
                idx_q <= 2'd2;
                st_q  <= SQ_START;
              end
            end else begin
              bit_q <= 3'd7;
              st_q  <= SQ_RX;
            end
          end
          SQ_RX: begin
            sh_q <= {sh_q[6:0], rbit};
            if (bit_q == 3'd0) begin
              vld_q  <= 1'b1;
              data_q <= {sh_q[6:0], rbit};
              addr_q <= sa_q + 8'(nb_q);
              nb_q   <= nb_q + 1'b1;
              st_q   <= SQ_ACKTX;
            end else begin
              bit_q <= bit_q - 3'd1;
            end
          end
          SQ_ACKTX: begin
            if (last_byte) st_q <= SQ_STOP;
            else begin
              bit_q <= 3'd7;
              st_q  <= SQ_RX;
            end
          end
          SQ_STOP: begin
            st_q   <= SQ_DONE;
            done_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q); // R8
  AST_DONE_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!sda_oe_o && !scl_oe_o)); // R8
  AST_ERR_NO_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (nb_q == '0)); // R7
  AST_VLD_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> ((nb_q <= cnt_q) && (nb_q != '0))); // R6
endmodule

// File: tb/i2c_seq_loader_tb.sv
module i2c_seq_loader_tb;
  localparam int unsigned CLK = 50_000_000;
  localparam int unsigned SCL = 2_500_000;
  localparam int unsigned CW  = 9;
  localparam int Q = (CLK + 4 * SCL - 1) / (4 * SCL);

  typedef struct packed {
    logic [7:0]    sa;
    logic [CW-1:0] cnt;
    logic [1:0]    nk;    // 0 none, 1 refuse 0xA0, 2 refuse word addr, 3 refuse 0xA1
    logic          e_err;
    logic [CW-1:0] e_n;
    logic [1:0]    e_st;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 9'd4,  2'd0, 1'b0, 9'd4,  2'd2},
    '{8'h10, 9'd1,  2'd0, 1'b0, 9'd1,  2'd2},
    '{8'hFE, 9'd4,  2'd0, 1'b0, 9'd4,  2'd2},
    '{8'h20, 9'd0,  2'd0, 1'b0, 9'd0,  2'd1},
    '{8'h30, 9'd3,  2'd1, 1'b1, 9'd0,  2'd1},
    '{8'h30, 9'd3,  2'd2, 1'b1, 9'd0,  2'd1},
    '{8'h30, 9'd3,  2'd3, 1'b1, 9'd0,  2'd2},
    '{8'h00, 9'd16, 2'd0, 1'b0, 9'd16, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] start_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic sda_oe, scl_oe, done, err, vld;
  logic [7:0] b_addr, b_data;
  logic slv_pull;
  wire  sda_line = !(sda_oe || slv_pull);
  wire  scl_line = !scl_oe;

  always #10 clk = ~clk;

  i2c_seq_loader #(.CLK_HZ(CLK), .SCL_HZ(SCL), .CNT_W(CW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sda_i        (sda_line),
    .start_addr_i (start_addr),
    .byte_cnt_i   (byte_cnt),
    .sda_oe_o     (sda_oe),
    .scl_oe_o     (scl_oe),
    .done_o       (done),
    .err_o        (err),
    .byte_vld_o   (vld),
    .byte_addr_o  (b_addr),
    .byte_data_o  (b_data)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom(input logic [7:0] a);
    return (a * 8'd37 + 8'd11) ^ 8'h5A;
  endfunction

  // behavioural EEPROM plus bus monitor
  logic [1:0] nk = 2'd0;
  int starts, stops, macks, mnacks, bitc, frame, nvld, mism, hcnt, pidx;
  int pw [4];
  logic prev_scl, prev_sda, txm, go_tx, mack;
  logic [7:0] sh, txsh, ptr;

  always @(negedge clk) begin
    if (!rst_n) begin
      slv_pull = 1'b0; prev_scl = 1'b1; prev_sda = 1'b1;
      starts = 0; stops = 0; macks = 0; mnacks = 0; bitc = 0; frame = 0;
      nvld = 0; mism = 0; hcnt = 0; pidx = 0;
      txm = 1'b0; go_tx = 1'b0; mack = 1'b0; sh = '0; txsh = '0; ptr = '0;
    end else begin
      if (vld) begin
        if (b_addr != 8'(start_addr + 8'(nvld)) || b_data != rom(8'(start_addr + 8'(nvld))))
          mism++;
        nvld++;
      end
      if (scl_line) hcnt++;
      else begin
        if (prev_scl) begin
          if (pidx < 4) pw[pidx] = hcnt;
          pidx++;
        end
        hcnt = 0;
      end
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        starts++; bitc = 0; frame = 0; txm = 1'b0; go_tx = 1'b0; slv_pull = 1'b0;
      end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
        stops++; bitc = 0; txm = 1'b0; slv_pull = 1'b0;
      end else if (!prev_scl && scl_line) begin
        if (!txm && bitc < 8) sh = {sh[6:0], sda_line};
        if (txm && bitc == 8) begin
          mack = !sda_line;
          if (sda_line) mnacks++; else macks++;
        end
        bitc++;
      end else if (prev_scl && !scl_line) begin
        if (!txm) begin
          if (bitc == 8) begin
            if (frame == 0) begin
              slv_pull = (sh == 8'hA0 && nk != 2'd1) || (sh == 8'hA1 && nk != 2'd3);
              go_tx = (sh == 8'hA1) && slv_pull;
            end else begin
              ptr = sh;
              slv_pull = (nk != 2'd2);
            end
          end else if (bitc == 9) begin
            slv_pull = 1'b0; bitc = 0; frame++;
            if (go_tx) begin
              txm = 1'b1; txsh = rom(ptr); ptr++; slv_pull = !txsh[7];
            end
          end
        end else begin
          if (bitc >= 1 && bitc <= 7) slv_pull = !txsh[7-bitc];
          else if (bitc == 8) slv_pull = 1'b0;
          else if (bitc == 9) begin
            bitc = 0;
            if (mack) begin
              txsh = rom(ptr); ptr++; slv_pull = !txsh[7];
            end else begin
              txm = 1'b0; slv_pull = 1'b0;
            end
          end
        end
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  task automatic apply_reset(input vec_t v);
    rst_n = 1'b0;
    start_addr = v.sa;
    byte_cnt = v.cnt;
    nk = v.nk;
    repeat (3) @(negedge clk);
    chk(!sda_oe && !scl_oe, "R1 lines released in reset", {sda_oe, scl_oe}, 0);
    chk(!done && !err && !vld, "R1 flags clear in reset", {done, err, vld}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input vec_t v);
    int e_ack;
    apply_reset(v);
    for (int i = 0; i < 40000 && !done; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R8 done after load", done, 1);
    chk(err == v.e_err, v.e_err ? "R7 error flag on refused address" : "R7 no error", err, v.e_err);
    chk(nvld == int'(v.e_n), v.cnt == 0 ? "R9 no strobes for zero count" : "R6 strobe count", nvld, v.e_n);
    chk(mism == 0, (int'(v.sa) + int'(v.cnt) > 256) ? "R10 wrapped addr/data" : "R6 addr/data", mism, 0);
    chk(starts == int'(v.e_st), "R3 START count", starts, v.e_st);
    chk(stops == 1, "R4 STOP count", stops, 1);
    e_ack = (v.e_n > 0) ? int'(v.e_n) - 1 : 0;
    chk(macks == e_ack, "R5 master ACKs", macks, e_ack);
    chk(mnacks == ((v.e_n > 0) ? 1 : 0), "R5 master NACK on last", mnacks, (v.e_n > 0) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NV; k++) begin
      run_vec(VEC[k]);
      if (k == 0) begin
        chk(pw[1] == 2 * Q + 1, "R2 START high width", pw[1], 2 * Q + 1);
        chk(pw[2] == 2 * Q + 1, "R2 bit high width", pw[2], 2 * Q + 1);
        repeat (60) @(negedge clk);
        chk(done && !err, "R8 done held", {done, err}, 2);
        chk(!sda_oe && !scl_oe, "R8 bus released after STOP", {sda_oe, scl_oe}, 0);
      end
    end
    // reset in the middle of a transfer
    apply_reset(VEC[7]);
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!sda_oe && !scl_oe, "R1 mid-load reset releases bus", {sda_oe, scl_oe}, 0);
    chk(!done && !err && !vld, "R1 mid-load reset clears flags", {done, err, vld}, 0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule